// File: doc/BRIEF.md
# Low-Power Mode Controller

This block is the state machine that holds the chip's current power mode and drives the clock-gate and regulator controls for it. Software selects a run mode with a request strobe and a 2-bit code. It also sets a deep-sleep flag and a stop-variant selector. A wait-for-interrupt pulse then sends the chip into the wait or stop-class mode that matches these settings and the current run mode.

There are three wakeup inputs: one from the main interrupt controller, one from an asynchronous wakeup-interrupt detector and one from a low-leakage wakeup unit. Each sleep mode responds only to its own source. On wakeup the controller returns to the run mode it left. The clock enables come back one cycle before the status code changes.

The outputs are core, system/flash and peripheral clock enables, a high-speed clock permit, the low-power regulator select, the low-voltage-detect enable, the reduced-rate flash select, an SRAM retention code, a 4-bit mode status code and a wakeup error flag. Regulators, oscillators and SRAM power switches sit outside the block.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is held and right after it, the mode code is 0 (normal run). All clocks are enabled, the high-speed permit is off, the regulator is in full-power operation (low-power select 0), low-voltage detect is on, flash runs at full rate, the SRAM code is 00 (active) and the error flag is 0.
- R2: A wait-for-interrupt with deep sleep clear enters a wait mode. From normal run this is code 2, with the core clock off and the system and peripheral clocks on. From very-low-power run this is code 5, with the same clocks and the low-power regulator, detect off and slow flash.
- R3: A wait-for-interrupt with deep sleep set and stop variant 0, from normal run, enters normal stop (code 3). All three clocks are off, the regulator stays in full-power operation, low-voltage detect stays on and the SRAM code is 01 (retain all).
- R4: Run request code 2 in normal run enters very-low-power run (code 4). All clocks are on, the low-power regulator is selected, detect is off and flash runs at reduced rate. A deep-sleep wait-for-interrupt there enters very-low-power stop (code 6) whatever the stop variant is, with all clocks off. Run request code 0 returns to normal run.
- R5: A deep-sleep wait-for-interrupt from normal run with stop variant 1, 2 or 3 enters low-leakage stop A (code 7, SRAM 01), low-leakage stop B (code 8, SRAM 10, partial retention) or very-low-leakage stop (code 9, SRAM 01). All clocks are off, the low-power regulator is selected and detect is off.
- R6: Codes 2 and 5 wake only on the interrupt-controller input. Codes 3 and 6 wake only on the asynchronous wakeup input. Codes 7, 8 and 9 wake only on the low-leakage wakeup input. A wakeup input that does not belong to the current mode leaves every output unchanged.
- R7: Take a wakeup sampled at a clock edge. From the next cycle the clock, regulator, detect, flash and SRAM outputs show the return run mode, while the mode code still shows the sleep mode. One cycle later the code becomes the return run mode: 4 for codes 5 and 6, and 0 for every other sleep mode.
- R8: Run request code 1 in normal run enters high-speed run (code 1) with the high-speed permit on. In very-low-power run that request is rejected and the mode stays 4. In high-speed run only request code 0 has an effect, and it returns to normal run.
- R9: A wakeup from code 7 or 8 while the low-leakage wakeup interrupt is masked sets the error flag. The flag appears in the same cycle the clocks return, and it stays set until the next entry into a sleep mode. The exit still completes. A wakeup from code 9 never sets the flag.
- R10: The wait-for-interrupt input is ignored in sleep modes, during the wakeup cycle and in high-speed run. Run requests are ignored outside the run modes and for code 3. If a wait-for-interrupt and a run request come in the same run-mode cycle, the wait-for-interrupt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_req_vld_i | input | 1 | Run-mode request strobe |
| run_req_i | input | 2 | Requested run mode: 0 normal, 1 high-speed, 2 very-low-power |
| deep_i | input | 1 | Deep-sleep flag |
| stop_sel_i | input | 2 | Stop variant for deep sleep from normal run |
| wfi_i | input | 1 | Wait-for-interrupt pulse |
| irq_wake_i | input | 1 | Wakeup from the main interrupt controller |
| async_wake_i | input | 1 | Wakeup from the asynchronous wakeup-interrupt detector |
| ll_wake_i | input | 1 | Wakeup from the low-leakage wakeup unit |
| ll_irq_mask_i | input | 1 | Low-leakage wakeup interrupt is masked |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System and flash clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hs_clk_en_o | output | 1 | High-speed core clock permit |
| lp_reg_o | output | 1 | Low-power regulator select |
| lvd_en_o | output | 1 | Low-voltage-detect enable |
| flash_slow_o | output | 1 | Reduced-rate flash access |
| sram_ret_o | output | 2 | SRAM state: 00 active, 01 retain all, 10 retain partial |
| mode_o | output | 4 | Current mode code |
| wake_err_o | output | 1 | Masked low-leakage wakeup error |

## Verification
The controller has no tunable parameters. The bench builds it with the package widths: a 4-bit mode code, 2-bit request and stop-variant fields and a 2-bit SRAM code. These widths give exactly the ten modes, so random strobes of request, deep flag, stop variant, mask and all three wakeup lines reach every mode. They also reach every wakeup path, including wrong-source and masked cases. Directed runs pin each mode's clock pattern, the one-cycle gap between clocks returning and the code changing, and the high-speed rejection from very-low-power run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 4;
  localparam int REQ_W  = 2;
  localparam int SEL_W  = 2;
  localparam int SRAM_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN  = 4'd0,
    M_HS   = 4'd1,
    M_WAIT = 4'd2,
    M_STOP = 4'd3,
    M_VLPR = 4'd4,
    M_VLPW = 4'd5,
    M_VLPS = 4'd6,
    M_LLSA = 4'd7,
    M_LLSB = 4'd8,
    M_VLLS = 4'd9
  } mode_e;

  localparam logic [REQ_W-1:0]  REQ_NORM = 2'd0;
  localparam logic [REQ_W-1:0]  REQ_HS   = 2'd1;
  localparam logic [REQ_W-1:0]  REQ_VLP  = 2'd2;

  localparam logic [SRAM_W-1:0] SRAM_ACT  = 2'd0;
  localparam logic [SRAM_W-1:0] SRAM_ALL  = 2'd1;
  localparam logic [SRAM_W-1:0] SRAM_PART = 2'd2;

  typedef struct packed {
    logic              core;
    logic              sys;
    logic              periph;
    logic              hs;
    logic              lp_reg;
    logic              lvd;
    logic              flash_slow;
    logic [SRAM_W-1:0] sram;
  } ctrl_t;

  function automatic mode_e ret_mode(mode_e m);
    return (m == M_VLPW || m == M_VLPS) ? M_VLPR : M_RUN;
  endfunction

  function automatic logic is_sleep(mode_e m);
    return !(m == M_RUN || m == M_HS || m == M_VLPR);
  endfunction
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
  import lpm_pkg::*;
(
  input  mode_e mode_i,
  input  logic  irq_wake_i,
  input  logic  async_wake_i,
  input  logic  ll_wake_i,
  input  logic  ll_irq_mask_i,
  output logic  wake_o,
  output logic  err_o
);
  always_comb begin
    wake_o = 1'b0;
    err_o  = 1'b0;
    unique case (mode_i)
      M_WAIT, M_VLPW: wake_o = irq_wake_i;
      M_STOP, M_VLPS: wake_o = async_wake_i;
      M_LLSA, M_LLSB: begin
        wake_o = ll_wake_i;
        err_o  = ll_wake_i & ll_irq_mask_i;
      end
      M_VLLS:         wake_o = ll_wake_i;
      default:        wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_next.sv
module lpm_next
  import lpm_pkg::*;
(
  input  mode_e            mode_i,
  input  logic             waking_i,
  input  logic             wfi_i,
  input  logic             deep_i,
  input  logic [SEL_W-1:0] stop_sel_i,
  input  logic             req_vld_i,
  input  logic [REQ_W-1:0] req_i,
  input  logic             wake_i,
  output mode_e            mode_o,
  output logic             waking_o,
  output logic             enter_sleep_o
);
  mode_e stop_pick;

  always_comb begin
    unique case (stop_sel_i)
      2'd1:    stop_pick = M_LLSA;
      2'd2:    stop_pick = M_LLSB;
      2'd3:    stop_pick = M_VLLS;
      default: stop_pick = M_STOP;
    endcase
  end

  always_comb begin
    mode_o        = mode_i;
    waking_o      = 1'b0;
    enter_sleep_o = 1'b0;
    if (waking_i) begin
      mode_o = ret_mode(mode_i);
    end else begin
      unique case (mode_i)
        M_RUN: begin
          if (wfi_i) begin
            mode_o        = deep_i ? stop_pick : M_WAIT;
            enter_sleep_o = 1'b1;
          end else if (req_vld_i && req_i == REQ_HS) begin
            mode_o = M_HS;
          end else if (req_vld_i && req_i == REQ_VLP) begin
            mode_o = M_VLPR;
          end
        end
        M_HS: begin
          if (req_vld_i && req_i == REQ_NORM) mode_o = M_RUN;
        end
        M_VLPR: begin
          if (wfi_i) begin
            mode_o        = deep_i ? M_VLPS : M_VLPW;
            enter_sleep_o = 1'b1;
          end else if (req_vld_i && req_i == REQ_NORM) begin
            mode_o = M_RUN;
          end
        end
        default: waking_o = wake_i;
      endcase
    end
  end
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
  import lpm_pkg::*;
(
  input  mode_e mode_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o = '{core: 1'b1, sys: 1'b1, periph: 1'b1, hs: 1'b0, lp_reg: 1'b0,
               lvd: 1'b1, flash_slow: 1'b0, sram: SRAM_ACT};
    unique case (mode_i)
      M_RUN: ;
      M_HS:  ctrl_o.hs = 1'b1;
      M_WAIT: ctrl_o.core = 1'b0;
      M_STOP: begin
        ctrl_o.core   = 1'b0;
        ctrl_o.sys    = 1'b0;
        ctrl_o.periph = 1'b0;
        ctrl_o.sram   = SRAM_ALL;
      end
      M_VLPR, M_VLPW: begin
        ctrl_o.core       = (mode_i == M_VLPR);
        ctrl_o.lp_reg     = 1'b1;
        ctrl_o.lvd        = 1'b0;
        ctrl_o.flash_slow = 1'b1;
      end
      default: begin
        ctrl_o.core       = 1'b0;
        ctrl_o.sys        = 1'b0;
        ctrl_o.periph     = 1'b0;
        ctrl_o.lp_reg     = 1'b1;
        ctrl_o.lvd        = 1'b0;
        ctrl_o.flash_slow = 1'b1;
        ctrl_o.sram       = (mode_i == M_LLSB) ? SRAM_PART : SRAM_ALL;
      end
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_req_vld_i,
  input  logic [REQ_W-1:0]  run_req_i,
  input  logic              deep_i,
  input  logic [SEL_W-1:0]  stop_sel_i,
  input  logic              wfi_i,
  input  logic              irq_wake_i,
  input  logic              async_wake_i,
  input  logic              ll_wake_i,
  input  logic              ll_irq_mask_i,
  output logic              core_clk_en_o,
  output logic              sys_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              hs_clk_en_o,
  output logic              lp_reg_o,
  output logic              lvd_en_o,
  output logic              flash_slow_o,
  output logic [SRAM_W-1:0] sram_ret_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              wake_err_o
);
  mode_e mode_q, mode_d, dec_mode;
  logic  waking_q, waking_d, err_q, err_d;
  logic  wake_hit, err_hit, enter_sleep;
  ctrl_t ctrl;

  lpm_wake_sel u_wake (
    .mode_i        (mode_q),
    .irq_wake_i    (irq_wake_i),
    .async_wake_i  (async_wake_i),
    .ll_wake_i     (ll_wake_i),
    .ll_irq_mask_i (ll_irq_mask_i),
    .wake_o        (wake_hit),
    .err_o         (err_hit)
  );

  lpm_next u_next (
    .mode_i        (mode_q),
    .waking_i      (waking_q),
    .wfi_i         (wfi_i),
    .deep_i        (deep_i),
    .stop_sel_i    (stop_sel_i),
    .req_vld_i     (run_req_vld_i),
    .req_i         (run_req_i),
    .wake_i        (wake_hit),
    .mode_o        (mode_d),
    .waking_o      (waking_d),
    .enter_sleep_o (enter_sleep)
  );

  // sticky until the next sleep entry
  always_comb begin
    err_d = err_q;
    if (enter_sleep)                         err_d = 1'b0;
    else if (!waking_q && wake_hit && err_hit) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= M_RUN;
      waking_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      waking_q <= waking_d;
      err_q    <= err_d;
    end
  end

  // clocks follow the return mode during the wake cycle
  assign dec_mode = waking_q ? ret_mode(mode_q) : mode_q;

  lpm_out_dec u_dec (
    .mode_i (dec_mode),
    .ctrl_o (ctrl)
  );

  assign core_clk_en_o   = ctrl.core;
  assign sys_clk_en_o    = ctrl.sys;
  assign periph_clk_en_o = ctrl.periph;
  assign hs_clk_en_o     = ctrl.hs;
  assign lp_reg_o        = ctrl.lp_reg;
  assign lvd_en_o        = ctrl.lvd;
  assign flash_slow_o    = ctrl.flash_slow;
  assign sram_ret_o      = ctrl.sram;
  assign mode_o          = mode_q;
  assign wake_err_o      = err_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ll_wake_i,
  input logic              ll_irq_mask_i,
  input logic              core_clk_en_o,
  input logic              sys_clk_en_o,
  input logic              periph_clk_en_o,
  input logic              lp_reg_o,
  input logic              lvd_en_o,
  input logic              flash_slow_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              wake_err_o
);
  assert_reset_run_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (mode_o == M_RUN && core_clk_en_o && lvd_en_o && !lp_reg_o && !wake_err_o));

  assert_wait_clocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WAIT || mode_o == M_VLPW) |-> (sys_clk_en_o && periph_clk_en_o));

  assert_stop_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_STOP && !core_clk_en_o) |-> (!sys_clk_en_o && !periph_clk_en_o && lvd_en_o));

  assert_vlpr_reg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_VLPR) |-> (lp_reg_o && !lvd_en_o && flash_slow_o));

  assert_wake_code_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> $stable(mode_o));

  assert_wake_code_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |=> (mode_o == M_RUN || mode_o == M_VLPR));

  assert_no_hs_from_vlpr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_VLPR) |=> (mode_o != M_HS));

  assert_masked_wake_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == M_LLSA || mode_o == M_LLSB) && !core_clk_en_o && ll_wake_i && ll_irq_mask_i)
    |=> wake_err_o);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ll_wake_i       (ll_wake_i),
  .ll_irq_mask_i   (ll_irq_mask_i),
  .core_clk_en_o   (core_clk_en_o),
  .sys_clk_en_o    (sys_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .lp_reg_o        (lp_reg_o),
  .lvd_en_o        (lvd_en_o),
  .flash_slow_o    (flash_slow_o),
  .mode_o          (mode_o),
  .wake_err_o      (wake_err_o)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_req_vld_i = 1'b0;
  logic [1:0] run_req_i = '0;
  logic       deep_i = 1'b0;
  logic [1:0] stop_sel_i = '0;
  logic       wfi_i = 1'b0;
  logic       irq_wake_i = 1'b0;
  logic       async_wake_i = 1'b0;
  logic       ll_wake_i = 1'b0;
  logic       ll_irq_mask_i = 1'b0;
  logic       core_clk_en_o, sys_clk_en_o, periph_clk_en_o, hs_clk_en_o;
  logic       lp_reg_o, lvd_en_o, flash_slow_o, wake_err_o;
  logic [1:0] sram_ret_o;
  logic [3:0] mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int  m_mode = 0;
  bit  m_wak  = 1'b0;
  bit  m_err  = 1'b0;

  always #4 clk_i = ~clk_i;

  lpm_ctrl dut (.*);

  function automatic int ret_of(int md);
    return (md == 5 || md == 6) ? 4 : 0;
  endfunction

  // {core,sys,periph,hs,lp_reg,lvd,slow,sram[1:0]} per requirement tables
  function automatic logic [8:0] pat_of(int md);
    case (md)
      0: return 9'b111_0_0_1_0_00;
      1: return 9'b111_1_0_1_0_00;
      2: return 9'b011_0_0_1_0_00;
      3: return 9'b000_0_0_1_0_01;
      4: return 9'b111_0_1_0_1_00;
      5: return 9'b011_0_1_0_1_00;
      6: return 9'b000_0_1_0_1_01;
      7: return 9'b000_0_1_0_1_01;
      8: return 9'b000_0_1_0_1_10;
      default: return 9'b000_0_1_0_1_01;
    endcase
  endfunction

  function automatic string tag_of(int md, bit wak);
    if (wak) return "R7";
    case (md)
      0: return "R1";
      1: return "R8";
      2, 5: return "R2";
      3: return "R3";
      4, 6: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic bit wake_ok(int md);
    case (md)
      2, 5: return irq_wake_i;
      3, 6: return async_wake_i;
      7, 8, 9: return ll_wake_i;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    if (m_wak) begin
      m_mode = ret_of(m_mode);
      m_wak  = 1'b0;
    end else if (m_mode == 0) begin
      if (wfi_i) begin
        m_err  = 1'b0;
        m_mode = !deep_i ? 2 : (stop_sel_i == 0 ? 3 : 6 + int'(stop_sel_i));
      end else if (run_req_vld_i && run_req_i == 1) m_mode = 1;
      else if (run_req_vld_i && run_req_i == 2) m_mode = 4;
    end else if (m_mode == 1) begin
      if (run_req_vld_i && run_req_i == 0) m_mode = 0;
    end else if (m_mode == 4) begin
      if (wfi_i) begin
        m_err  = 1'b0;
        m_mode = deep_i ? 6 : 5;
      end else if (run_req_vld_i && run_req_i == 0) m_mode = 0;
    end else if (wake_ok(m_mode)) begin
      m_wak = 1'b1;
      if ((m_mode == 7 || m_mode == 8) && ll_irq_mask_i) m_err = 1'b1;
    end
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    string t;
    t = (tag == "") ? tag_of(m_mode, m_wak) : tag;
    check(t, {5'd0, mode_o}, {5'd0, 4'(m_mode)});
    check(t, {core_clk_en_o, sys_clk_en_o, periph_clk_en_o, hs_clk_en_o, lp_reg_o,
              lvd_en_o, flash_slow_o, sram_ret_o},
          pat_of(m_wak ? ret_of(m_mode) : m_mode));
    check("R9", {8'd0, wake_err_o}, {8'd0, m_err});
  endtask

  task automatic idle();
    run_req_vld_i = 0; run_req_i = 0; wfi_i = 0;
    irq_wake_i = 0; async_wake_i = 0; ll_wake_i = 0;
  endtask

  // inputs are set at a negedge; one edge later outputs are compared
  task automatic cyc(input string tag);
    model_step();
    @(negedge clk_i);
    compare(tag);
    idle();
  endtask

  task automatic req(input int code, input string tag);
    run_req_vld_i = 1; run_req_i = 2'(code); cyc(tag);
  endtask

  task automatic sleep(input bit dp, input int sel, input string tag);
    wfi_i = 1; deep_i = dp; stop_sel_i = 2'(sel); cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // wait from normal run, wrong sources, ignored wfi and request
    sleep(0, 0, "R2");
    async_wake_i = 1; cyc("R6");
    ll_wake_i = 1;    cyc("R6");
    wfi_i = 1;        cyc("R10");
    req(1, "R10");
    irq_wake_i = 1;   cyc("R7");
    cyc("R7");

    // normal stop
    sleep(1, 0, "R3");
    irq_wake_i = 1;   cyc("R6");
    async_wake_i = 1; cyc("R7");
    wfi_i = 1;        cyc("R10");

    // very-low-power run and its sleeps
    req(2, "R4");
    req(1, "R8");
    sleep(1, 2, "R4");
    ll_wake_i = 1;    cyc("R6");
    async_wake_i = 1; cyc("R7");
    cyc("R4");
    sleep(0, 3, "R2");
    async_wake_i = 1; cyc("R6");
    irq_wake_i = 1;   cyc("R7");
    cyc("R2");
    req(0, "R4");

    // low-leakage stops with and without mask
    for (int s = 1; s <= 3; s++) begin
      sleep(1, s, "R5");
      irq_wake_i = 1; async_wake_i = 1; cyc("R6");
      ll_irq_mask_i = 1; ll_wake_i = 1; cyc("R9");
      cyc("R9");
      ll_irq_mask_i = 0;
      sleep(1, s, "R9");
      ll_wake_i = 1; cyc("R7");
      cyc("R5");
    end

    // high-speed run
    req(1, "R8");
    sleep(0, 0, "R10");
    req(2, "R8");
    req(3, "R8");
    req(0, "R8");
    // wfi beats a same-cycle request
    run_req_vld_i = 1; run_req_i = 2; wfi_i = 1; deep_i = 0; cyc("R10");
    irq_wake_i = 1; cyc("R7");
    cyc("R7");

    void'($urandom(32'd4711));
    for (int i = 0; i < 6000; i++) begin
      wfi_i         = ($urandom % 8) == 0;
      deep_i        = $urandom % 2;
      stop_sel_i    = 2'($urandom % 4);
      run_req_vld_i = ($urandom % 6) == 0;
      run_req_i     = 2'($urandom % 4);
      irq_wake_i    = ($urandom % 10) == 0;
      async_wake_i  = ($urandom % 10) == 0;
      ll_wake_i     = ($urandom % 10) == 0;
      ll_irq_mask_i = ($urandom % 3) == 0;
      cyc("");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule